// File: doc/BRIEF.md
# Peripheral Request Handshake Tracker

This block sits on the DMA side of one peripheral request handshake. A peripheral sends typed requests over a valid/ready request bus: single-transfer requests, burst-transfer requests and flush acknowledgements. Each request carries a flag that marks the final request of a transfer sequence. The block replies over a valid/ready acknowledge bus with single-done and burst-done completions, and it uses the same bus to issue flush requests.

Up to `MAX_PENDING` (default four) transfer requests can be outstanding. They are held in arrival order. The oldest one is shown to a channel engine together with its burst and final flags. When the engine has serviced that request it raises `done_req`. The block then sends the matching completion, and the request is retired when the peripheral takes that completion. At that point the block reports the retired request's final flag.

The engine can also start a flush. The flush discards every outstanding request, sends a flush request to the peripheral, and ignores new transfer requests until the peripheral returns a flush acknowledgement.

Back-pressure rules:
- A transfer happens on either bus only at a clock edge where valid and ready are both high.
- `req_ready` is low while the queue is full in normal operation.
- `ack_valid` and `ack_kind` are held unchanged until `ack_ready` is seen.

Top module: `periph_handshake_tracker`

## Requirements
- R1: A request is taken only on a clock edge with `req_valid` and `req_ready` both high. Kinds 00 (single) and 01 (burst) are queued in arrival order. The oldest queued request appears on `head_valid`, `head_burst` (1 = burst) and `head_final`, and `pending_cnt` gives the number held.
- R2: In normal operation `req_ready` is low while `MAX_PENDING` requests are outstanding, and a request offered then is not taken.
- R3: In normal operation, a request of kind 10 (flush acknowledge) or 11 (reserved) is taken and leaves the queue and `pending_cnt` unchanged.
- R4: `done_ready` is high when all of the following hold: a request is outstanding, no acknowledge is pending, no flush is in progress, and `flush_cmd` is low. One cycle after `done_req` is accepted, `ack_valid` is 1 and `ack_kind` is 00 for a single request or 01 for a burst request.
- R5: While `ack_valid` is high and `ack_ready` is low, `ack_valid` and `ack_kind` stay unchanged.
- R6: When a single-done or burst-done acknowledge is taken, the oldest request retires. In that cycle `retire_valid` pulses and `retire_final` equals that request's final flag.
- R7: `flush_cmd` is accepted while `flush_ready` is high, which means no flush is in progress and no acknowledge is pending. One cycle later the queue is empty, `ack_valid` is 1 with `ack_kind` 10, and `flush_busy` is 1.
- R8: While `flush_busy` is high, `req_ready` is 1 and single and burst requests are dropped. A kind 10 request taken after the flush request's acknowledge handshake clears `flush_busy` one cycle later, and normal queuing resumes.
- R9: After reset the queue is empty, `ack_valid` is 0, `req_ready` is 1 and `flush_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Peripheral request valid |
| req_kind | input | 2 | Request type: 00 single, 01 burst, 10 flush ack, 11 reserved |
| req_final | input | 1 | Request is the final request of the sequence |
| req_ready | output | 1 | Request can be taken |
| ack_valid | output | 1 | Acknowledge valid |
| ack_kind | output | 2 | Acknowledge type: 00 single done, 01 burst done, 10 flush request |
| ack_ready | input | 1 | Peripheral takes the acknowledge |
| head_valid | output | 1 | An outstanding request exists |
| head_burst | output | 1 | Oldest request is a burst |
| head_final | output | 1 | Oldest request carries the final flag |
| pending_cnt | output | $clog2(MAX_PENDING+1) | Number of outstanding requests |
| done_req | input | 1 | Engine finished servicing the oldest request |
| done_ready | output | 1 | `done_req` can be accepted |
| retire_valid | output | 1 | Oldest request retired this cycle |
| retire_final | output | 1 | Final flag of the retired request |
| flush_cmd | input | 1 | Engine asks for a flush |
| flush_ready | output | 1 | `flush_cmd` can be accepted |
| flush_busy | output | 1 | Flush exchange in progress |

## Verification
The queue is tested in three ways:
- A mixed run of single and burst requests with differing final flags. A scoreboard compares each retirement with it, so a wrong order, kind or final flag shows as a mismatch.
- Filling the queue to four and offering a fifth request. This separates correct back-pressure from overflow.
- Delaying `ack_ready` by several cycles. This exposes an acknowledge that changes or drops before the handshake.

Reserved and flush-acknowledge requests sent during normal operation show whether stray kinds disturb the queue. A flush issued with requests outstanding, followed by a transfer request sent while waiting and then the flush acknowledgement, checks that discarding and resumption each occur at the right point.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    REQ_SINGLE    = 2'b00,
    REQ_BURST     = 2'b01,
    REQ_FLUSH_ACK = 2'b10,
    REQ_RSVD      = 2'b11
  } req_kind_e;

  typedef enum logic [1:0] {
    ACK_SINGLE_DONE = 2'b00,
    ACK_BURST_DONE  = 2'b01,
    ACK_FLUSH_REQ   = 2'b10
  } ack_kind_e;

  typedef enum logic [1:0] {
    ST_RUN      = 2'b00,
    ST_FL_ISSUE = 2'b01,
    ST_FL_WAIT  = 2'b10
  } hs_state_e;

  typedef struct packed {
    logic final_flag;
    logic burst;
  } pend_ent_t;
endpackage

// File: rtl/hs_pend_queue.sv
module hs_pend_queue
  import hs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             push,
  input  pend_ent_t                        push_ent,
  input  logic                             pop,
  output pend_ent_t                        head_ent,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic                             full,
  output logic                             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  pend_ent_t        slots [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !clear && wr_q == PW'(i)) slots[i] <= push_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= step(wr_q);
      if (pop)  rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_ent = slots[rd_q];
  assign count    = cnt_q;
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
endmodule

// File: rtl/hs_req_intake.sv
module hs_req_intake
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  hs_state_e  state,
  input  logic       q_full,
  input  logic       flush_take,
  output logic       req_ready,
  output logic       push,
  output logic       flush_ack_seen
);
  logic fire;
  logic xfer_kind;

  assign req_ready      = (state == ST_RUN) ? !q_full : 1'b1;
  assign fire           = req_valid && req_ready;
  assign xfer_kind      = (req_kind == REQ_SINGLE) || (req_kind == REQ_BURST);
  assign push           = fire && (state == ST_RUN) && xfer_kind && !flush_take;
  assign flush_ack_seen = fire && (state == ST_FL_WAIT) && (req_kind == REQ_FLUSH_ACK);

  assert_push_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> req_valid);
endmodule

// File: rtl/hs_ack_ctrl.sv
module hs_ack_ctrl
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_req,
  input  logic       flush_cmd,
  input  logic       head_valid,
  input  logic       head_burst,
  input  logic       ack_ready,
  input  logic       flush_ack_seen,
  output logic       ack_valid,
  output logic [1:0] ack_kind,
  output logic       done_ready,
  output logic       flush_ready,
  output logic       flush_take,
  output logic       retire,
  output hs_state_e  state,
  output logic       flush_busy
);
  hs_state_e st_q;
  logic      ack_v_q;
  ack_kind_e ack_k_q;
  logic      ack_fire;
  logic      done_take;

  assign ack_fire    = ack_v_q && ack_ready;
  assign flush_ready = (st_q == ST_RUN) && !ack_v_q;
  assign flush_take  = flush_cmd && flush_ready;
  assign done_ready  = (st_q == ST_RUN) && head_valid && !ack_v_q && !flush_cmd;
  assign done_take   = done_req && done_ready;
  assign retire      = ack_fire && (st_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      ack_v_q <= 1'b0;
      ack_k_q <= ACK_SINGLE_DONE;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (flush_take) begin
            st_q    <= ST_FL_ISSUE;
            ack_v_q <= 1'b1;
            ack_k_q <= ACK_FLUSH_REQ;
          end else if (done_take) begin
            ack_v_q <= 1'b1;
            ack_k_q <= head_burst ? ACK_BURST_DONE : ACK_SINGLE_DONE;
          end else if (ack_fire) begin
            ack_v_q <= 1'b0;
          end
        end
        ST_FL_ISSUE: begin
          if (ack_fire) begin
            ack_v_q <= 1'b0;
            st_q    <= ST_FL_WAIT;
          end
        end
        ST_FL_WAIT: begin
          if (flush_ack_seen) st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign ack_valid  = ack_v_q;
  assign ack_kind   = ack_k_q;
  assign state      = st_q;
  assign flush_busy = (st_q != ST_RUN);

  assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_kind)));
  assert_done_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_take && !flush_take) |=> (ack_valid && (ack_kind[0] == head_burst) && !ack_kind[1]));
endmodule

// File: rtl/periph_handshake_tracker.sv
module periph_handshake_tracker
  import hs_pkg::*;
#(
  parameter int MAX_PENDING = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic [1:0]                           req_kind,
  input  logic                                 req_final,
  output logic                                 req_ready,
  output logic                                 ack_valid,
  output logic [1:0]                           ack_kind,
  input  logic                                 ack_ready,
  output logic                                 head_valid,
  output logic                                 head_burst,
  output logic                                 head_final,
  output logic [$clog2(MAX_PENDING+1)-1:0]     pending_cnt,
  input  logic                                 done_req,
  output logic                                 done_ready,
  output logic                                 retire_valid,
  output logic                                 retire_final,
  input  logic                                 flush_cmd,
  output logic                                 flush_ready,
  output logic                                 flush_busy
);
  hs_state_e state;
  pend_ent_t head_ent;
  pend_ent_t new_ent;
  logic      q_full, q_empty, push, retire, flush_take, flush_ack_seen;

  assign new_ent = '{final_flag: req_final, burst: req_kind[0]};

  hs_pend_queue #(.DEPTH(MAX_PENDING)) u_queue (
    .clk(clk), .rst_n(rst_n), .clear(flush_take), .push(push),
    .push_ent(new_ent), .pop(retire), .head_ent(head_ent),
    .count(pending_cnt), .full(q_full), .empty(q_empty)
  );

  hs_req_intake u_intake (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .state(state), .q_full(q_full), .flush_take(flush_take),
    .req_ready(req_ready), .push(push), .flush_ack_seen(flush_ack_seen)
  );

  hs_ack_ctrl u_ack (
    .clk(clk), .rst_n(rst_n), .done_req(done_req), .flush_cmd(flush_cmd),
    .head_valid(head_valid), .head_burst(head_burst), .ack_ready(ack_ready),
    .flush_ack_seen(flush_ack_seen), .ack_valid(ack_valid), .ack_kind(ack_kind),
    .done_ready(done_ready), .flush_ready(flush_ready), .flush_take(flush_take),
    .retire(retire), .state(state), .flush_busy(flush_busy)
  );

  assign head_valid   = !q_empty;
  assign head_burst   = head_ent.burst;
  assign head_final   = head_ent.final_flag;
  assign retire_valid = retire;
  assign retire_final = head_ent.final_flag;

  assert_retire_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> (ack_valid && ack_ready && head_valid));
endmodule

// File: tb/periph_handshake_tracker_test.sv
module periph_handshake_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_final = 1'b0, ack_ready = 1'b0;
  logic done_req = 1'b0, flush_cmd = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic req_ready, ack_valid, head_valid, head_burst, head_final;
  logic done_ready, retire_valid, retire_final, flush_ready, flush_busy;
  logic [1:0] ack_kind;
  logic [2:0] pending_cnt;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] sb_q[$];   // {final, burst}

  always #5 clk = ~clk;

  periph_handshake_tracker #(.MAX_PENDING(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_final(req_final), .req_ready(req_ready), .ack_valid(ack_valid),
    .ack_kind(ack_kind), .ack_ready(ack_ready), .head_valid(head_valid),
    .head_burst(head_burst), .head_final(head_final), .pending_cnt(pending_cnt),
    .done_req(done_req), .done_ready(done_ready), .retire_valid(retire_valid),
    .retire_final(retire_final), .flush_cmd(flush_cmd), .flush_ready(flush_ready),
    .flush_busy(flush_busy)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of retirements
  always @(negedge clk) begin
    if (rst_n && retire_valid) begin
      if (sb_q.size() == 0) begin
        check_eq("R6 unexpected retire", 1, 0);
      end else begin
        logic [1:0] e;
        e = sb_q.pop_front();
        check_eq("R6 retire_final", int'(retire_final), int'(e[1]));
        check_eq("R1 retire order kind", int'(ack_kind), int'(e[0]));
      end
    end
  end

  task automatic send_req(input logic [1:0] kind, input logic fin, input bit queued);
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = kind; req_final = fin;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (queued) sb_q.push_back({fin, kind[0]});
  endtask

  task automatic complete(input int hold);
    int exp_kind;
    exp_kind = int'(sb_q[0][0]);
    @(posedge clk); #1 done_req = 1'b1;
    @(negedge clk);
    while (!done_ready) @(negedge clk);
    @(posedge clk); #1 done_req = 1'b0;
    @(negedge clk);
    check_eq("R4 ack_valid", int'(ack_valid), 1);
    check_eq("R4 ack_kind", int'(ack_kind), exp_kind);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check_eq("R5 ack_valid held", int'(ack_valid), 1);
      check_eq("R5 ack_kind held", int'(ack_kind), exp_kind);
    end
    @(posedge clk); #1 ack_ready = 1'b1;
    @(posedge clk); #1 ack_ready = 1'b0;
    @(negedge clk);
    check_eq("R6 ack dropped after handshake", int'(ack_valid), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 ack_valid", int'(ack_valid), 0);
    check_eq("R9 req_ready", int'(req_ready), 1);
    check_eq("R9 pending", int'(pending_cnt), 0);
    check_eq("R9 flush_busy", int'(flush_busy), 0);
    check_eq("R9 head_valid", int'(head_valid), 0);

    // fill to four
    send_req(2'b00, 1'b0, 1);
    send_req(2'b01, 1'b0, 1);
    send_req(2'b00, 1'b1, 1);
    send_req(2'b01, 1'b1, 1);
    @(negedge clk);
    check_eq("R1 pending full", int'(pending_cnt), 4);
    check_eq("R2 req_ready low when full", int'(req_ready), 0);
    check_eq("R1 head_valid", int'(head_valid), 1);
    check_eq("R1 head_burst", int'(head_burst), 0);
    check_eq("R1 head_final", int'(head_final), 0);
    // offer fifth
    @(posedge clk); #1 req_valid = 1'b1; req_kind = 2'b01;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_eq("R2 ready stays low", int'(req_ready), 0);
    end
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    check_eq("R2 fifth not taken", int'(pending_cnt), 4);

    complete(3);
    check_eq("R2 ready after retire", int'(req_ready), 1);
    check_eq("R6 pending after retire", int'(pending_cnt), 3);
    check_eq("R1 next head burst", int'(head_burst), 1);
    complete(0);
    complete(1);
    complete(0);
    check_eq("R6 queue drained", int'(pending_cnt), 0);

    // stray kinds in normal operation
    send_req(2'b11, 1'b0, 0);
    @(negedge clk);
    check_eq("R3 reserved ignored", int'(pending_cnt), 0);
    send_req(2'b10, 1'b1, 0);
    @(negedge clk);
    check_eq("R3 flush ack ignored", int'(pending_cnt), 0);
    check_eq("R3 head empty", int'(head_valid), 0);
    check_eq("R3 no flush state", int'(flush_busy), 0);

    // flush with outstanding requests
    send_req(2'b01, 1'b0, 1);
    send_req(2'b00, 1'b1, 1);
    @(posedge clk); #1 flush_cmd = 1'b1;
    @(negedge clk);
    check_eq("R7 flush_ready", int'(flush_ready), 1);
    @(posedge clk); #1 flush_cmd = 1'b0;
    sb_q.delete();
    @(negedge clk);
    check_eq("R7 queue emptied", int'(pending_cnt), 0);
    check_eq("R7 ack_valid", int'(ack_valid), 1);
    check_eq("R7 ack_kind flush", int'(ack_kind), 2);
    check_eq("R7 flush_busy", int'(flush_busy), 1);
    @(negedge clk);
    check_eq("R5 flush req held", int'(ack_kind), 2);
    @(posedge clk); #1 ack_ready = 1'b1;
    @(posedge clk); #1 ack_ready = 1'b0;
    @(negedge clk);
    check_eq("R7 flush req taken", int'(ack_valid), 0);
    check_eq("R8 still busy", int'(flush_busy), 1);
    check_eq("R8 req_ready in flush", int'(req_ready), 1);
    send_req(2'b00, 1'b0, 0);
    @(negedge clk);
    check_eq("R8 transfer dropped", int'(pending_cnt), 0);
    check_eq("R8 busy until flush ack", int'(flush_busy), 1);
    send_req(2'b10, 1'b0, 0);
    @(negedge clk);
    check_eq("R8 flush ack ends flush", int'(flush_busy), 0);
    send_req(2'b01, 1'b1, 1);
    @(negedge clk);
    check_eq("R8 queuing resumed", int'(pending_cnt), 1);
    complete(0);
    check_eq("R6 scoreboard empty", sb_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule